// File: doc/BRIEF.md
# Quad-Core Cluster Control Registers

This block is the register file that sits beside a four-core processor cluster. Software reaches it through a 32-bit word bus with a single-cycle write and a read whose data appears one cycle later. It keeps one 64-bit boot address per core, split over a low and a high word, and drives each assembled value to its core. It also holds a few plain configuration words.

Two small functions live inside the block. The first is a one-source interrupt unit: a hardware event sets a status bit, and software clears that bit by writing one to it. A mask bit gates the interrupt line. Software never writes the mask directly. It changes the mask through a write-one-to-unmask register and a write-one-to-mask register. The second is a power-down path. A per-core request bit in the power-control word is the core's power status output. That same bit, combined with the core's live wait-for-interrupt input, forms a handshake to the power manager.

The block has no state machine. All state is in register fields that the address decoder selects. Every output is the registered state, or a combination of that state with live inputs.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: After reset the reads return these values: error control 0, config 0 `0x00000F0F`, config 1 0, coherency control `0x000F000F`, snoop control 0, status 0, mask 1, power control 0, power status 0. Each boot low word reads `0xFFFF0000` and each boot high word reads 0. After reset `irq_out`, `wfi_hs`, `pwr_status` and `rdata` are all 0.
- R2: `rdata` carries the value selected by `addr` in the cycle `rd_en` was high, starting at the next clock edge. It holds its value during cycles without `rd_en`. A read returns the value from before any write made in the same cycle.
- R3: The status word (byte offset 0x10) has a single bit, bit 0. A pulse on `irq_event` sets it. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. If an event and a clearing write fall in the same cycle, the bit ends up set.
- R4: Writes to the mask word (0x14) have no effect. Writing the unmask word (0x18) clears every mask bit whose data bit is 1. Writing the mask-set word (0x1C) sets every mask bit whose data bit is 1. Both of these words read as 0.
- R5: `irq_out` is high exactly when status bit 0 is 1 and mask bit 0 is 0. It follows the clock edge of the event or write that changes either bit.
- R6: Core i has its boot low word at byte offset 0x40+8i and its high word at 0x44+8i. The output `rvbar_out[64i+63:64i]` equals {high, low} and changes after the edge of a write to either word.
- R7: Bits [3:0] of the power-control word (0x90) are the per-core requests. All 32 bits read back as written. `pwr_status[i]` equals request bit i and changes only after a write to 0x90.
- R8: `wfi_hs[i]` equals `pwr_status[i] & wfi_in[i]` at all times, with no clock delay from `wfi_in`.
- R9: In the power status word (0x94), bits [17:16] and [3:0] always read 0 and ignore writes. All other bits store what is written.
- R10: An address with a nonzero value in bits [1:0], or one outside the map, reads as 0 and ignores writes. Examples are 0x30 and 0x60.
- R11: Error control (0x00), config 0 (0x20), config 1 (0x24), coherency control (0x80) and snoop control (0x84) are 32-bit storage that read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_event | input | 1 | One-cycle interrupt event |
| wfi_in | input | 4 | Per-core wait-for-interrupt level |
| irq_out | output | 1 | Unmasked interrupt |
| pwr_status | output | 4 | Per-core power-down request status |
| wfi_hs | output | 4 | Per-core power-manager handshake |
| rvbar_out | output | 256 | Per-core 64-bit boot address, core 0 in the low bits |

## Verification
The hardest situation to reach from the ports is a clearing write to the status word that lands in the same cycle as a new event. Two other hard paths are an unmask or mask-set write that has to reach `irq_out` by the next edge, and a direct mask write that must change nothing. Directed cycles drive the event and the status write together on purpose, and they walk through the mask, unmask and mask-set words in sequence. A seeded random phase then mixes events, writes and reads across the whole map, including misaligned and unmapped addresses. Throughout that phase it toggles `wfi_in` against all sixteen request patterns.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t A_ERRCTL = 8'h00;
    localparam addr_t A_STATUS = 8'h10;
    localparam addr_t A_MASK   = 8'h14;
    localparam addr_t A_IEN    = 8'h18;
    localparam addr_t A_IDS    = 8'h1C;
    localparam addr_t A_CFG0   = 8'h20;
    localparam addr_t A_CFG1   = 8'h24;
    localparam addr_t A_VEC    = 8'h40;
    localparam addr_t A_ACE    = 8'h80;
    localparam addr_t A_SNOOP  = 8'h84;
    localparam addr_t A_PWRCTL = 8'h90;
    localparam addr_t A_PSTAT  = 8'h94;

    localparam word_t RST_CFG0   = 32'h0000_0F0F;
    localparam word_t RST_ACE    = 32'h000F_000F;
    localparam word_t RST_VEC_LO = 32'hFFFF_0000;
    localparam word_t PSTAT_RO   = 32'h0003_000F;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ERRCTL,
        SEL_STATUS,
        SEL_MASK,
        SEL_IEN,
        SEL_IDS,
        SEL_CFG0,
        SEL_CFG1,
        SEL_VEC,
        SEL_ACE,
        SEL_SNOOP,
        SEL_PWRCTL,
        SEL_PSTAT
    } reg_sel_e;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  addr_t            addr,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] vec_idx,
    output logic             vec_hi
);
    localparam addr_t VEC_SPAN = addr_t'(N_CORES * 8);

    addr_t voff;

    always_comb begin
        voff    = addr - A_VEC;
        vec_idx = voff[IDX_W+2:3];
        vec_hi  = voff[2];
        sel     = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr >= A_VEC && voff < VEC_SPAN) begin
                sel = SEL_VEC;
            end else begin
                unique case (addr)
                    A_ERRCTL: sel = SEL_ERRCTL;
                    A_STATUS: sel = SEL_STATUS;
                    A_MASK:   sel = SEL_MASK;
                    A_IEN:    sel = SEL_IEN;
                    A_IDS:    sel = SEL_IDS;
                    A_CFG0:   sel = SEL_CFG0;
                    A_CFG1:   sel = SEL_CFG1;
                    A_ACE:    sel = SEL_ACE;
                    A_SNOOP:  sel = SEL_SNOOP;
                    A_PWRCTL: sel = SEL_PWRCTL;
                    A_PSTAT:  sel = SEL_PSTAT;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ccr_irq_unit.sv
module ccr_irq_unit #(
    parameter int ISR_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] event_in,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic             dis_we,
    input  logic [ISR_W-1:0] wbits,
    output logic [ISR_W-1:0] status_q,
    output logic [ISR_W-1:0] mask_q,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            // a new event overrides a clearing write in the same cycle
            status_q <= event_in | (status_q & ~(clr_we ? wbits : '0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (en_we) begin
            mask_q <= mask_q & ~wbits;
        end else if (dis_we) begin
            mask_q <= mask_q | wbits;
        end
    end

    assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/ccr_power_unit.sv
module ccr_power_unit
    import ccr_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  word_t              wdata,
    input  logic [N_CORES-1:0] wfi_in,
    output word_t              ctl_q,
    output logic [N_CORES-1:0] req,
    output logic [N_CORES-1:0] hs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= wdata;
        end
    end

    assign req = ctl_q[N_CORES-1:0];

    for (genvar c = 0; c < N_CORES; c++) begin : g_hs
        assign hs[c] = req[c] & wfi_in[c];
    end
endmodule

// File: rtl/ccr_vector_bank.sv
module ccr_vector_bank
    import ccr_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 hi_sel,
    input  word_t                wdata,
    output word_t                rd_word,
    output logic [N_CORES*64-1:0] vec_flat
);
    word_t lo_q [N_CORES];
    word_t hi_q [N_CORES];

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[c] <= RST_VEC_LO;
                hi_q[c] <= '0;
            end else if (we && idx == IDX_W'(c)) begin
                if (hi_sel) begin
                    hi_q[c] <= wdata;
                end else begin
                    lo_q[c] <= wdata;
                end
            end
        end
        assign vec_flat[c*64 +: 64] = {hi_q[c], lo_q[c]};
    end

    assign rd_word = hi_sel ? hi_q[idx] : lo_q[idx];
endmodule

// File: rtl/cluster_ctrl_regs.sv
module cluster_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ISR_W   = 1,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  irq_event,
    input  logic [N_CORES-1:0]    wfi_in,
    output logic                  irq_out,
    output logic [N_CORES-1:0]    pwr_status,
    output logic [N_CORES-1:0]    wfi_hs,
    output logic [N_CORES*64-1:0] rvbar_out
);
    reg_sel_e         sel;
    logic [IDX_W-1:0] vec_idx;
    logic             vec_hi;
    logic [ISR_W-1:0] irq_status;
    logic [ISR_W-1:0] irq_mask;
    word_t            vec_word;
    word_t            pwr_ctl;
    word_t            err_q, cfg0_q, cfg1_q, ace_q, snoop_q, pstat_q;
    word_t            rd_next;
    word_t            rdata_q;

    ccr_decode #(.N_CORES(N_CORES)) u_dec (
        .addr    (addr),
        .sel     (sel),
        .vec_idx (vec_idx),
        .vec_hi  (vec_hi)
    );

    ccr_irq_unit #(.ISR_W(ISR_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in ({{(ISR_W-1){1'b0}}, irq_event}),
        .clr_we   (wr_en && sel == SEL_STATUS),
        .en_we    (wr_en && sel == SEL_IEN),
        .dis_we   (wr_en && sel == SEL_IDS),
        .wbits    (wdata[ISR_W-1:0]),
        .status_q (irq_status),
        .mask_q   (irq_mask),
        .irq      (irq_out)
    );

    ccr_power_unit #(.N_CORES(N_CORES)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (wr_en && sel == SEL_PWRCTL),
        .wdata  (wdata),
        .wfi_in (wfi_in),
        .ctl_q  (pwr_ctl),
        .req    (pwr_status),
        .hs     (wfi_hs)
    );

    ccr_vector_bank #(.N_CORES(N_CORES)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en && sel == SEL_VEC),
        .idx      (vec_idx),
        .hi_sel   (vec_hi),
        .wdata    (wdata),
        .rd_word  (vec_word),
        .vec_flat (rvbar_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= '0;
            cfg0_q  <= RST_CFG0;
            cfg1_q  <= '0;
            ace_q   <= RST_ACE;
            snoop_q <= '0;
            pstat_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_ERRCTL: err_q   <= wdata;
                SEL_CFG0:   cfg0_q  <= wdata;
                SEL_CFG1:   cfg1_q  <= wdata;
                SEL_ACE:    ace_q   <= wdata;
                SEL_SNOOP:  snoop_q <= wdata;
                SEL_PSTAT:  pstat_q <= (pstat_q & PSTAT_RO) | (wdata & ~PSTAT_RO);
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ERRCTL: rd_next = err_q;
            SEL_STATUS: rd_next = DATA_W'(irq_status);
            SEL_MASK:   rd_next = DATA_W'(irq_mask);
            SEL_CFG0:   rd_next = cfg0_q;
            SEL_CFG1:   rd_next = cfg1_q;
            SEL_VEC:    rd_next = vec_word;
            SEL_ACE:    rd_next = ace_q;
            SEL_SNOOP:  rd_next = snoop_q;
            SEL_PWRCTL: rd_next = pwr_ctl;
            SEL_PSTAT:  rd_next = pstat_q;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_next;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic                  wbit0,
    input logic                  irq_event,
    input logic                  irq_out,
    input logic                  status0,
    input logic                  mask0,
    input logic [N_CORES-1:0]    wfi_in,
    input logic [N_CORES-1:0]    wfi_hs,
    input logic [N_CORES-1:0]    pwr_status,
    input logic [N_CORES*64-1:0] rvbar_out
);
    localparam addr_t VEC_END = A_VEC + addr_t'(N_CORES * 8);

    logic vec_wr;
    assign vec_wr = wr_en && addr >= A_VEC && addr < VEC_END;

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> status0);

    a_r4_mask_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK) |=> $stable(mask0));

    a_r5_unmask_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IEN && wbit0 && status0) |=> irq_out);

    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_PWRCTL) |=> $stable(pwr_status));

    a_r8_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        wfi_hs == (pwr_status & wfi_in));

    a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wr |=> $stable(rvbar_out));
endmodule

bind cluster_ctrl_regs ccr_checker #(.N_CORES(N_CORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wbit0      (wdata[0]),
    .irq_event  (irq_event),
    .irq_out    (irq_out),
    .status0    (irq_status[0]),
    .mask0      (irq_mask[0]),
    .wfi_in     (wfi_in),
    .wfi_hs     (wfi_hs),
    .pwr_status (pwr_status),
    .rvbar_out  (rvbar_out)
);

// File: tb/cluster_ctrl_regs_test.sv
module cluster_ctrl_regs_test;
    import ccr_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    addr_t        addr = '0;
    word_t        wdata = '0;
    word_t        rdata;
    logic         irq_event = 1'b0;
    logic [3:0]   wfi_in = '0;
    logic         irq_out;
    logic [3:0]   pwr_status;
    logic [3:0]   wfi_hs;
    logic [255:0] rvbar_out;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    word_t m_err, m_cfg0, m_cfg1, m_ace, m_snoop, m_pwr, m_pstat;
    word_t m_lo [4];
    word_t m_hi [4];
    logic  m_stat, m_mask;
    word_t last_rd;

    always #2 clk = ~clk;

    cluster_ctrl_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .irq_event  (irq_event),
        .wfi_in     (wfi_in),
        .irq_out    (irq_out),
        .pwr_status (pwr_status),
        .wfi_hs     (wfi_hs),
        .rvbar_out  (rvbar_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_err = '0; m_cfg0 = 32'h0F0F; m_cfg1 = '0; m_ace = 32'h000F000F;
        m_snoop = '0; m_pwr = '0; m_pstat = '0;
        for (int i = 0; i < 4; i++) begin
            m_lo[i] = 32'hFFFF0000;
            m_hi[i] = '0;
        end
        m_stat = 1'b0; m_mask = 1'b1; last_rd = '0;
    endtask

    function automatic word_t m_read(input addr_t a);
        if (a[1:0] != 2'b00) return '0;
        if (a >= 8'h40 && a < 8'h60) return a[2] ? m_hi[(a - 8'h40) >> 3] : m_lo[(a - 8'h40) >> 3];
        case (a)
            8'h00: return m_err;
            8'h10: return {31'd0, m_stat};
            8'h14: return {31'd0, m_mask};
            8'h20: return m_cfg0;
            8'h24: return m_cfg1;
            8'h80: return m_ace;
            8'h84: return m_snoop;
            8'h90: return m_pwr;
            8'h94: return m_pstat;
            default: return '0;
        endcase
    endfunction

    task automatic m_write(input addr_t a, input word_t d);
        if (a[1:0] != 2'b00) return;
        if (a >= 8'h40 && a < 8'h60) begin
            if (a[2]) m_hi[(a - 8'h40) >> 3] = d;
            else      m_lo[(a - 8'h40) >> 3] = d;
            return;
        end
        case (a)
            8'h00: m_err = d;
            8'h10: if (d[0]) m_stat = 1'b0;
            8'h18: if (d[0]) m_mask = 1'b0;
            8'h1C: if (d[0]) m_mask = 1'b1;
            8'h20: m_cfg0 = d;
            8'h24: m_cfg1 = d;
            8'h80: m_ace = d;
            8'h84: m_snoop = d;
            8'h90: m_pwr = d;
            8'h94: m_pstat = d & ~32'h0003000F;
            default: ;
        endcase
    endtask

    function automatic logic [255:0] m_vec();
        logic [255:0] v;
        for (int i = 0; i < 4; i++) v[i*64 +: 64] = {m_hi[i], m_lo[i]};
        return v;
    endfunction

    // one bus cycle: drive at negedge, check at the following negedge
    task automatic cyc(input logic we, input logic re, input addr_t a, input word_t d,
                       input logic ev, input logic [3:0] wfi, input string tag);
        word_t exp_rd;
        exp_rd = m_read(a);
        wr_en = we; rd_en = re; addr = a; wdata = d; irq_event = ev; wfi_in = wfi;
        @(posedge clk);
        #1;
        if (we) m_write(a, d);
        if (ev) m_stat = 1'b1;  // R3 set wins over clear
        if (re) last_rd = exp_rd;
        @(negedge clk);
        chk(re ? tag : "R2", "rdata", rdata, last_rd);
        chk("R5", "irq_out", irq_out, m_stat & ~m_mask);
        chk("R7", "pwr_status", pwr_status, m_pwr[3:0]);
        chk("R8", "wfi_hs", wfi_hs, m_pwr[3:0] & wfi);
        chk("R6", "rvbar_out", rvbar_out, m_vec());
        wr_en = 1'b0; rd_en = 1'b0; irq_event = 1'b0;
    endtask

    function automatic addr_t pick_addr();
        addr_t tbl [20] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                            8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58,
                            8'h5C, 8'h80, 8'h84, 8'h90, 8'h94, 8'h60};
        if ($urandom_range(0, 7) == 0) return addr_t'($urandom);
        return tbl[$urandom_range(0, 19)];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        addr_t r1_list [13] = '{8'h00, 8'h10, 8'h14, 8'h20, 8'h24, 8'h80,
                                8'h84, 8'h90, 8'h94, 8'h40, 8'h44, 8'h58, 8'h5C};
        void'($urandom(32'h5EED_0C1A));
        m_reset();
        repeat (3) @(negedge clk);
        // R1: outputs straight out of reset
        chk("R1", "irq_out", irq_out, 1'b0);
        chk("R1", "wfi_hs", wfi_hs, 4'h0);
        chk("R1", "pwr_status", pwr_status, 4'h0);
        chk("R1", "rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        foreach (r1_list[k]) cyc(0, 1, r1_list[k], '0, 0, 4'hF, "R1");

        // R11 plain storage
        cyc(1, 0, 8'h00, 32'hDEADBEEF, 0, 0, "R11");
        cyc(1, 0, 8'h20, 32'h12345678, 0, 0, "R11");
        cyc(1, 0, 8'h84, 32'hA5A5A5A5, 0, 0, "R11");
        cyc(0, 1, 8'h00, '0, 0, 0, "R11");
        cyc(0, 1, 8'h20, '0, 0, 0, "R11");
        cyc(0, 1, 8'h84, '0, 0, 0, "R11");
        // R2: read in the same cycle as a write returns the old value, then holds
        cyc(1, 1, 8'h24, 32'h0BADF00D, 0, 0, "R2");
        cyc(0, 0, 8'h24, '0, 0, 0, "R2");
        cyc(0, 1, 8'h24, '0, 0, 0, "R2");

        // R3 / R4 / R5 interrupt sequences
        cyc(0, 0, 8'h00, '0, 1, 0, "R3");            // event, still masked
        cyc(0, 1, 8'h10, '0, 0, 0, "R3");
        cyc(1, 0, 8'h14, 32'h0, 0, 0, "R4");         // direct mask write ignored
        cyc(0, 1, 8'h14, '0, 0, 0, "R4");
        cyc(1, 0, 8'h18, 32'h1, 0, 0, "R5");         // unmask: irq rises
        cyc(0, 1, 8'h18, '0, 0, 0, "R4");
        cyc(0, 1, 8'h1C, '0, 0, 0, "R4");
        cyc(1, 0, 8'h10, 32'h0, 0, 0, "R3");         // write 0: no clear
        cyc(1, 0, 8'h10, 32'h1, 1, 0, "R3");         // event + clear: set wins
        cyc(0, 1, 8'h10, '0, 0, 0, "R3");
        cyc(1, 0, 8'h10, 32'h1, 0, 0, "R3");         // clear
        cyc(0, 1, 8'h10, '0, 0, 0, "R3");
        cyc(1, 0, 8'h14, 32'h1, 0, 0, "R4");
        cyc(0, 1, 8'h14, '0, 0, 0, "R4");
        cyc(0, 0, 8'h00, '0, 1, 0, "R5");
        cyc(1, 0, 8'h1C, 32'h1, 0, 0, "R5");         // mask again: irq falls
        cyc(0, 1, 8'h14, '0, 0, 0, "R4");

        // R6 boot addresses for every core
        for (int c = 0; c < 4; c++) begin
            cyc(1, 0, addr_t'(8'h40 + 8*c), 32'h1000_0000 + c, 0, 0, "R6");
            cyc(1, 0, addr_t'(8'h44 + 8*c), 32'h0000_00A0 + c, 0, 0, "R6");
            cyc(0, 1, addr_t'(8'h44 + 8*c), '0, 0, 0, "R6");
        end

        // R7 / R8 all sixteen request and wfi combinations
        for (int q = 0; q < 16; q++) begin
            cyc(1, 0, 8'h90, 32'hABCD_0000 | q, 0, 0, "R7");
            cyc(1, 0, 8'h90, 32'hABCD_0000 | q, 0, 0, "R7");
            for (int w = 0; w < 16; w++) cyc(0, 0, 8'h00, '0, 0, 4'(w), "R8");
        end
        cyc(0, 1, 8'h90, '0, 0, 0, "R7");

        // R9 read-only bits in power status
        cyc(1, 0, 8'h94, 32'hFFFF_FFFF, 0, 0, "R9");
        cyc(0, 1, 8'h94, '0, 0, 0, "R9");

        // R10 misaligned and unmapped
        cyc(1, 0, 8'h91, 32'h0000_0005, 0, 0, "R10");
        cyc(0, 1, 8'h91, '0, 0, 0, "R10");
        cyc(1, 0, 8'h30, 32'hFFFF_FFFF, 0, 0, "R10");
        cyc(0, 1, 8'h30, '0, 0, 0, "R10");
        cyc(1, 0, 8'h60, 32'h1234_5678, 0, 0, "R10");
        cyc(0, 1, 8'h60, '0, 0, 0, "R10");
        cyc(0, 1, 8'h40, '0, 0, 0, "R10");

        // random mix across the map
        for (int it = 0; it < 1500; it++) begin
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick_addr(),
                word_t'($urandom), ($urandom_range(0, 5) == 0), 4'($urandom), "R11");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule